// File: doc/BRIEF.md
# Presettable Divide-by-N Johnson Counter

This block divides its clock by any whole number N from 2 to 10 with a chain of five shift stages wired as a Johnson ring. A 4-bit ratio input picks N. The block then selects the feedback into the first stage from the stage outputs. For even N it uses one output. For odd N it uses the AND of two neighbouring outputs, which drops one state from the ring. The stage outputs use an inverted sense: a stage output is the complement of the bit that stage holds. Stage 1 therefore loads the inverse of the feedback term.

Two level-sensitive controls override counting. A reset drives every stage output high at once. A preset-enable drives each stage output to the inverse of its jam input. Both act on the outputs as soon as they are raised. When either control is dropped, the chain waits two more rising edges, so that the release is synchronised to the clock, and then resumes counting. Gating on the active part of the chain detects any state that cannot occur in the ring, for example one loaded by preset or left behind by a ratio change, and steers the chain back into the ring.

Top module: `johnson_divn`

## Requirements
- R1: While `rst_i` is 1, every bit of `q_o` is 1 and `div_o` is 1, at once and independent of the clock. Reset wins over `preset_i`.
- R2: While `preset_i` is 1 and `rst_i` is 0, `q_o` equals the bitwise inverse of `jam_i`, at once and independent of the clock.
- R3: After reset or preset-enable falls, `q_o` holds its value across the next two rising edges. Shifting resumes on the third rising edge.
- R4: On each counting edge, `q_o[k]` takes the old `q_o[k-1]` and `q_o[0]` takes the inverse of the feedback term. The only exception is the recovery step of R8, which loads all ones. With N=10 and starting from all ones, the state reached after s shifts (s taken mod 10) has bits i<s cleared when s<=5. When s>5 it has only bits i<s-5 set.
- R5: For even N, the feedback and `div_o` come from `q_o[N/2-1]`. `div_o` has period N, and it is high for N/2 clocks and low for N/2 clocks.
- R6: For odd N, let t=(N-1)/2. The feedback is `q_o[t] & q_o[t-1]` and `div_o` is `q_o[t]`. `div_o` has period N and is high for (N+1)/2 clocks.
- R7: A ratio value below 2 or above 10 behaves exactly as N=10.
- R8: From any 5-bit state loaded by preset, `div_o` runs with the correct period and duty for the selected N within 10 counting edges.
- R9: A change of `ratio_i` while counting takes effect on the next edge. Within 10 edges, `div_o` runs with the period and duty of the new N.
- R10: `div_o` always equals the `q_o` bit named in R5 and R6 for the current ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_i | input | 1 | Active-high reset to all ones, asynchronous assert |
| preset_i | input | 1 | Active-high jam load, asynchronous assert |
| jam_i | input | 5 | Preset data, loaded inverted |
| ratio_i | input | 4 | Division ratio N |
| q_o | output | 5 | Stage outputs, bit 0 is stage 1 |
| div_o | output | 1 | Divided clock output |

## Verification
The checker tests three things on every clock. It confirms the reset and preset overrides on `q_o`. It confirms that `q_o` stays frozen on the first edge after either control is released. It also confirms that every counting edge is either a one-place shift or the all-ones recovery load. Period and duty per ratio, the mapping of out-of-range ratios, recovery from every possible preset pattern and settling after a ratio change are properties of whole runs of clocks. Only the bench's sweeps show those, by timing the high and low phases of `div_o`.

// File: rtl/johnson_divn_pkg.sv
package johnson_divn_pkg;

  // Effective ratio: out-of-range values fall back to the longest ring.
  function automatic int unsigned eff_ratio(input int unsigned r, input int unsigned max_n);
    if (r < 2 || r > max_n) return max_n;
    return r;
  endfunction

  // Count of neighbouring bit changes inside the active window.
  function automatic int unsigned edge_count(input logic [31:0] diff, input logic [31:0] mask);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(diff[i] & mask[i]);
    return n;
  endfunction

endpackage

// File: rtl/johnson_divn_sync.sv
module johnson_divn_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic lvl_i,
  output logic hold_o
);
  logic [SYNC_STAGES-1:0] sh;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) sh <= lvl_i;
    end else begin : g_many
      always_ff @(posedge clk) sh <= {sh[SYNC_STAGES-2:0], lvl_i};
    end
  endgenerate

  assign hold_o = lvl_i | (|sh);
endmodule

// File: rtl/johnson_divn_decode.sv
module johnson_divn_decode
  import johnson_divn_pkg::*;
#(
  parameter int STAGES  = 5,
  parameter int RATIO_W = 4,
  localparam int IDX_W  = $clog2(STAGES)
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [IDX_W-1:0]   tap_o,
  output logic               odd_o,
  output logic [STAGES-2:0]  win_o
);
  localparam int unsigned MAX_N = 2 * STAGES;

  int unsigned n_eff;

  always_comb begin
    n_eff = eff_ratio(int'(ratio_i), MAX_N);
    tap_o = IDX_W'((n_eff - 1) >> 1);
    odd_o = n_eff[0];
  end

  generate
    for (genvar i = 0; i < STAGES - 1; i++) begin : g_win
      assign win_o[i] = (i < int'(tap_o));
    end
  endgenerate
endmodule

// File: rtl/johnson_divn_chain.sv
module johnson_divn_chain
  import johnson_divn_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int IDX_W = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              rst_hold_i,
  input  logic              pre_now_i,
  input  logic              pre_hold_i,
  input  logic [STAGES-1:0] jam_i,
  input  logic [IDX_W-1:0]  tap_i,
  input  logic              odd_i,
  input  logic [STAGES-2:0] win_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] q;
  logic [IDX_W-1:0]  tap_lo;
  logic              fb;
  logic              bad;
  logic [STAGES-2:0] diff;

  always_comb begin
    tap_lo = (tap_i == '0) ? '0 : tap_i - 1'b1;
    fb     = odd_i ? (q[tap_i] & q[tap_lo]) : q[tap_i];
    diff   = q[STAGES-1:1] ^ q[STAGES-2:0];
    bad    = edge_count(32'(diff), 32'(win_i)) > 1;
  end

  always_ff @(posedge clk) begin
    if (rst_hold_i)      q <= '1;
    else if (pre_now_i)  q <= ~jam_i;
    else if (pre_hold_i) q <= q;
    else if (bad)        q <= '1;
    else                 q <= {q[STAGES-2:0], ~fb};
  end

  assign q_o = q;
endmodule

// File: rtl/johnson_divn.sv
module johnson_divn #(
  parameter int STAGES      = 5,
  parameter int RATIO_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_i,
  input  logic               preset_i,
  input  logic [STAGES-1:0]  jam_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [STAGES-1:0]  q_o,
  output logic               div_o
);
  localparam int IDX_W = $clog2(STAGES);

  logic              rst_hold, pre_hold;
  logic [IDX_W-1:0]  tap;
  logic              odd;
  logic [STAGES-2:0] win;
  logic [STAGES-1:0] q_reg;

  johnson_divn_sync #(.SYNC_STAGES(SYNC_STAGES)) rst_sync_i (
    .clk(clk), .lvl_i(rst_i), .hold_o(rst_hold));

  johnson_divn_sync #(.SYNC_STAGES(SYNC_STAGES)) pre_sync_i (
    .clk(clk), .lvl_i(preset_i), .hold_o(pre_hold));

  johnson_divn_decode #(.STAGES(STAGES), .RATIO_W(RATIO_W)) dec_i (
    .ratio_i(ratio_i), .tap_o(tap), .odd_o(odd), .win_o(win));

  johnson_divn_chain #(.STAGES(STAGES)) chain_i (
    .clk(clk), .rst_hold_i(rst_hold), .pre_now_i(preset_i), .pre_hold_i(pre_hold),
    .jam_i(jam_i), .tap_i(tap), .odd_i(odd), .win_i(win), .q_o(q_reg));

  always_comb begin
    if (rst_i)         q_o = '1;
    else if (preset_i) q_o = ~jam_i;
    else               q_o = q_reg;
  end

  assign div_o = q_o[tap];
endmodule

// File: rtl/johnson_divn_chk.sv
module johnson_divn_chk #(
  parameter int STAGES      = 5,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_i,
  input logic              preset_i,
  input logic [STAGES-1:0] jam_i,
  input logic [STAGES-1:0] q_o,
  input logic              div_o
);
  localparam int CW = $clog2(SYNC_STAGES + 2);

  logic          quiet;
  logic [CW-1:0] quiet_cnt = '0;
  logic          count_edge;

  assign quiet      = !rst_i && !preset_i;
  assign count_edge = quiet && (int'(quiet_cnt) >= SYNC_STAGES);

  always_ff @(posedge clk) begin
    if (!quiet)                              quiet_cnt <= '0;
    else if (int'(quiet_cnt) < SYNC_STAGES)  quiet_cnt <= quiet_cnt + 1'b1;
  end

  AST_RST_ALL_ONES: assert property (@(posedge clk) rst_i |-> (q_o == '1 && div_o)); // R1
  AST_PRESET_INVERT: assert property (@(posedge clk) (preset_i && !rst_i) |-> q_o == ~jam_i); // R2
  AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (rst_i)
    (quiet && ($past(rst_i) || $past(preset_i))) |=> (preset_i || $stable(q_o))); // R3
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst_i || preset_i)
    $past(count_edge) |-> (q_o[STAGES-1:1] == $past(q_o[STAGES-2:0]) || q_o == '1)); // R4
endmodule

bind johnson_divn johnson_divn_chk #(.STAGES(STAGES), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk(clk), .rst_i(rst_i), .preset_i(preset_i), .jam_i(jam_i), .q_o(q_o), .div_o(div_o));

// File: tb/johnson_divn_tb.sv
module johnson_divn_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       preset_i = 1'b0;
  logic [4:0] jam_i = '0;
  logic [3:0] ratio_i = 4'd10;
  logic [4:0] q_o;
  logic       div_o;

  int n_chk = 0;
  int n_bad = 0;

  johnson_divn dut_i (.clk(clk), .rst_i(rst_i), .preset_i(preset_i), .jam_i(jam_i),
                      .ratio_i(ratio_i), .q_o(q_o), .div_o(div_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int n_of(input int r);
    return (r < 2 || r > 10) ? 10 : r;
  endfunction

  // Time one full high and low phase of div_o.
  task automatic measure(output int hi, output int lo);
    int g;
    hi = 0; lo = 0;
    g = 0; while (div_o !== 1'b0 && g < 30) begin step(); g++; end
    g = 0; while (div_o !== 1'b1 && g < 30) begin step(); g++; end
    while (div_o === 1'b1 && hi < 30) begin step(); hi++; end
    while (div_o === 1'b0 && lo < 30) begin step(); lo++; end
  endtask

  task automatic check_rate(input string req, input int r);
    int hi, lo, n;
    n = n_of(r);
    measure(hi, lo);
    check({req, " period"}, hi + lo, n);
    check({req, " high"}, hi, (n + 1) / 2);
  endtask

  task automatic do_reset(input logic [3:0] r);
    @(negedge clk); rst_i = 1'b1; ratio_i = r;
    step(); step();
    @(negedge clk); rst_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int s, exp, tap;
    step(); step();
    // R1: reset state, held through clocks
    check("R1 reset q", int'(q_o), 31);
    check("R1 reset div", int'(div_o), 1);
    @(negedge clk); preset_i = 1'b1; jam_i = 5'b10110; #1;
    check("R1 reset beats preset", int'(q_o), 31);
    @(negedge clk); preset_i = 1'b0;

    // R3, R4: exact sequence from reset at N=10
    @(negedge clk); rst_i = 1'b0;
    for (int t = 0; t < 24; t++) begin
      step();
      s = (t >= 2) ? (t - 1) % 10 : 0;
      exp = (s <= 5) ? ((31 << s) & 31) : ((1 << (s - 5)) - 1);
      check(t < 2 ? "R3 hold after reset" : "R4 shift sequence", int'(q_o), exp);
    end

    // R1: asynchronous assert mid-cycle
    @(negedge clk); #2 rst_i = 1'b1; #1;
    check("R1 async reset", int'(q_o), 31);

    // R5, R6, R7, R10: every ratio code
    for (int r = 0; r < 16; r++) begin
      do_reset(4'(r));
      repeat (12) step();
      tap = (n_of(r) - 1) / 2;
      check("R10 div tap", int'(div_o), int'(q_o[tap]));
      if (r < 2 || r > 10) check_rate("R7 out of range", r);
      else if (r % 2 == 0) check_rate("R5 even", r);
      else check_rate("R6 odd", r);
      step();
      check("R10 div tap", int'(div_o), int'(q_o[tap]));
    end

    // R2, R3, R8: every preset pattern at every ratio
    for (int r = 2; r <= 10; r++) begin
      for (int j = 0; j < 32; j++) begin
        @(negedge clk); rst_i = 1'b0; ratio_i = 4'(r); #2 preset_i = 1'b1; jam_i = 5'(j); #1;
        check("R2 async preset", int'(q_o), (~j) & 31);
        step();
        @(negedge clk); preset_i = 1'b0; jam_i = 5'(~j);
        step(); check("R3 hold after preset", int'(q_o), (~j) & 31);
        step(); check("R3 hold after preset", int'(q_o), (~j) & 31);
        repeat (10) step();
        check_rate("R8 recovery", r);
      end
    end

    // R9: ratio change while counting
    for (int a = 2; a <= 10; a++) begin
      for (int b = 2; b <= 10; b += 3) begin
        do_reset(4'(a));
        repeat (7 + a) step();
        @(negedge clk); ratio_i = 4'(b);
        repeat (10) step();
        check_rate("R9 ratio change", b);
      end
    end

    finish_run();
  end
endmodule